// File: doc/BRIEF.md
# Inclusive Snoop Filter

This block sits on the bus side of a shared coherence bus, between the bus and a group of caches. It follows every coherent transaction and every eviction notice, and it keeps a presence vector for each block it tracks. The vector has one bit per cache. When a transaction arrives, the filter forwards it only to the caches whose bit is set. The cache that issued the transaction is always left out. A block that no cache holds produces an empty mask, so no cache spends a tag lookup on it.

The table is direct-mapped, with one entry per index. The low address bits pick the entry and the remaining bits are stored as its tag. When a new block needs an entry that another block already holds, the old block is displaced. Before that happens, the filter sends a back-invalidation to every cache in the old block's vector, so the filter's record always covers everything the caches hold. All results appear one clock cycle after the transaction.

Top module: `snoop_filter`

## Requirements
- R1: After reset every table entry is empty and `snoop_valid` and `binv_valid` are low. A cycle without `bus_valid` gives low `snoop_valid` and low `binv_valid` on the next cycle.
- R2: A transaction whose block is not in the table gives `snoop_valid`=1, `snoop_hit`=0 and `snoop_mask`=0 one cycle later. The entry is then allocated, holding only the requester's bit.
- R3: A read (`bus_wr`=0) to a tracked block gives `snoop_hit`=1 and `snoop_mask` equal to the recorded vector without the requester's bit. The requester's bit is added to the vector.
- R4: A write or invalidate (`bus_wr`=1) gives the same mask as a read. Afterwards the vector holds only the writer's bit.
- R5: Bit `bus_src` of `snoop_mask` is never set for that transaction. Bit k of `snoop_mask` stands for cache k.
- R6: An eviction notice clears the evicting cache's bit. When the vector becomes zero, the entry is freed and the next access to that block misses.
- R7: When a miss lands on an index held by a different block, `binv_valid` rises in the same cycle as `snoop_valid`. `binv_addr` carries the displaced block's address and `binv_mask` its full vector.
- R8: An eviction and a bus transaction in the same cycle to the same index are applied in that order. The eviction first, then the bus transaction on the updated entry. An entry freed this way produces no back-invalidation.
- R9: An eviction notice for a block that is not in the table has no effect.
- R10: The table index is the low log2(ENTRIES) bits of a block address. The tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A coherent bus transaction is present |
| bus_addr | input | ADDR_W | Block address of the transaction |
| bus_wr | input | 1 | 0 = read, 1 = write or invalidate |
| bus_src | input | log2(NUM_CACHES) | Requesting cache |
| evict_valid | input | 1 | An eviction notice is present |
| evict_addr | input | ADDR_W | Block address being evicted |
| evict_src | input | log2(NUM_CACHES) | Evicting cache |
| snoop_valid | output | 1 | Snoop result for the previous cycle's transaction |
| snoop_hit | output | 1 | The block was tracked |
| snoop_mask | output | NUM_CACHES | Caches that must perform a tag lookup |
| binv_valid | output | 1 | A back-invalidation is issued |
| binv_addr | output | ADDR_W | Address of the displaced block |
| binv_mask | output | NUM_CACHES | Caches that must drop the displaced block |

## Verification
An eviction notice and a bus transaction can land on the same table entry in the same cycle. The bench drives both in one cycle. In the first case, the eviction leaves the entry alive, and the bench expects the evicting cache to be absent from the snoop mask. In the second case, the eviction empties the entry while the bus transaction would otherwise have displaced it, and the bench expects a clean miss with no back-invalidation.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } bus_op_e;
endpackage

// File: rtl/sf_table.sv
module sf_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 4,
  parameter int NC      = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rda_idx,
  output logic             rda_valid,
  output logic [TAG_W-1:0] rda_tag,
  output logic [NC-1:0]    rda_vec,
  input  logic [IDX_W-1:0] rdb_idx,
  output logic             rdb_valid,
  output logic [TAG_W-1:0] rdb_tag,
  output logic [NC-1:0]    rdb_vec,
  // port 0: eviction updates
  input  logic             wr0_en,
  input  logic [IDX_W-1:0] wr0_idx,
  input  logic             wr0_valid,
  input  logic [NC-1:0]    wr0_vec,
  // port 1: bus updates, wins over port 0 on the same index
  input  logic             wr1_en,
  input  logic [IDX_W-1:0] wr1_idx,
  input  logic [TAG_W-1:0] wr1_tag,
  input  logic [NC-1:0]    wr1_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [NC-1:0]      vec_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             sel0, sel1, en;
    logic             vld_d;
    logic [TAG_W-1:0] tag_d;
    logic [NC-1:0]    vec_d;

    always_comb begin
      sel0  = wr0_en && (wr0_idx == IDX_W'(g));
      sel1  = wr1_en && (wr1_idx == IDX_W'(g));
      en    = sel0 || sel1;
      vld_d = vld_q[g];
      tag_d = tag_q[g];
      vec_d = vec_q[g];
      if (sel1) begin
        vld_d = 1'b1;
        tag_d = wr1_tag;
        vec_d = wr1_vec;
      end else if (sel0) begin
        vld_d = wr0_valid;
        vec_d = wr0_vec;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        vec_q[g] <= '0;
      end else if (en) begin
        vld_q[g] <= vld_d;
        tag_q[g] <= tag_d;
        vec_q[g] <= vec_d;
      end
    end
  end

  assign rda_valid = vld_q[rda_idx];
  assign rda_tag   = tag_q[rda_idx];
  assign rda_vec   = vec_q[rda_idx];
  assign rdb_valid = vld_q[rdb_idx];
  assign rdb_tag   = tag_q[rdb_idx];
  assign rdb_vec   = vec_q[rdb_idx];
endmodule

// File: rtl/sf_evict_merge.sv
module sf_evict_merge #(
  parameter int TAG_W = 4,
  parameter int NC    = 4,
  localparam int SRC_W = $clog2(NC)
) (
  input  logic             ev_en,
  input  logic [TAG_W-1:0] ev_tag,
  input  logic [SRC_W-1:0] ev_src,
  input  logic             cur_valid,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic [NC-1:0]    cur_vec,
  output logic             ev_hit,
  output logic             new_valid,
  output logic [NC-1:0]    new_vec
);
  logic [NC-1:0] src_bit;

  always_comb begin
    src_bit   = NC'(1) << ev_src;
    ev_hit    = ev_en && cur_valid && (cur_tag == ev_tag);
    new_vec   = cur_vec & ~src_bit;
    new_valid = |new_vec;
  end
endmodule

// File: rtl/sf_bus_ctrl.sv
module sf_bus_ctrl #(
  parameter int TAG_W = 4,
  parameter int NC    = 4,
  localparam int SRC_W = $clog2(NC)
) (
  input  logic             cur_valid,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic [NC-1:0]    cur_vec,
  input  logic [TAG_W-1:0] bus_tag,
  input  sf_pkg::bus_op_e  bus_op,
  input  logic [SRC_W-1:0] bus_src,
  output logic             hit,
  output logic [NC-1:0]    mask,
  output logic [NC-1:0]    upd_vec,
  output logic             victim,
  output logic [NC-1:0]    victim_vec
);
  logic [NC-1:0] src_bit;

  always_comb begin
    src_bit    = NC'(1) << bus_src;
    hit        = cur_valid && (cur_tag == bus_tag);
    mask       = hit ? (cur_vec & ~src_bit) : '0;
    victim     = cur_valid && !hit;
    victim_vec = victim ? cur_vec : '0;
    if (hit && bus_op == sf_pkg::OP_READ) upd_vec = cur_vec | src_bit;
    else                                  upd_vec = src_bit;
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int NUM_CACHES = 4,
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 8,
  localparam int SRC_W     = $clog2(NUM_CACHES),
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = ADDR_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [SRC_W-1:0]      bus_src,
  input  logic                  evict_valid,
  input  logic [ADDR_W-1:0]     evict_addr,
  input  logic [SRC_W-1:0]      evict_src,
  output logic                  snoop_valid,
  output logic                  snoop_hit,
  output logic [NUM_CACHES-1:0] snoop_mask,
  output logic                  binv_valid,
  output logic [ADDR_W-1:0]     binv_addr,
  output logic [NUM_CACHES-1:0] binv_mask
);
  // address split (R10)
  logic [IDX_W-1:0] b_idx, e_idx;
  logic [TAG_W-1:0] b_tag, e_tag;
  assign b_idx = bus_addr[IDX_W-1:0];
  assign b_tag = bus_addr[ADDR_W-1:IDX_W];
  assign e_idx = evict_addr[IDX_W-1:0];
  assign e_tag = evict_addr[ADDR_W-1:IDX_W];

  logic                  ta_valid, tb_valid;
  logic [TAG_W-1:0]      ta_tag, tb_tag;
  logic [NUM_CACHES-1:0] ta_vec, tb_vec;
  logic                  ev_hit, ev_new_valid;
  logic [NUM_CACHES-1:0] ev_new_vec;
  logic                  v_valid;
  logic [NUM_CACHES-1:0] v_vec;
  logic                  bc_hit, bc_victim;
  logic [NUM_CACHES-1:0] bc_mask, bc_upd_vec, bc_victim_vec;
  sf_pkg::bus_op_e       op;

  assign op = sf_pkg::bus_op_e'(bus_wr);

  sf_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .NC(NUM_CACHES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rda_idx   (b_idx),
    .rda_valid (ta_valid),
    .rda_tag   (ta_tag),
    .rda_vec   (ta_vec),
    .rdb_idx   (e_idx),
    .rdb_valid (tb_valid),
    .rdb_tag   (tb_tag),
    .rdb_vec   (tb_vec),
    .wr0_en    (ev_hit),
    .wr0_idx   (e_idx),
    .wr0_valid (ev_new_valid),
    .wr0_vec   (ev_new_vec),
    .wr1_en    (bus_valid),
    .wr1_idx   (b_idx),
    .wr1_tag   (b_tag),
    .wr1_vec   (bc_upd_vec)
  );

  sf_evict_merge #(.TAG_W(TAG_W), .NC(NUM_CACHES)) u_evict (
    .ev_en     (evict_valid),
    .ev_tag    (e_tag),
    .ev_src    (evict_src),
    .cur_valid (tb_valid),
    .cur_tag   (tb_tag),
    .cur_vec   (tb_vec),
    .ev_hit    (ev_hit),
    .new_valid (ev_new_valid),
    .new_vec   (ev_new_vec)
  );

  // eviction is seen by a same-cycle bus transaction on that index (R8)
  always_comb begin
    if (ev_hit && (e_idx == b_idx)) begin
      v_valid = ev_new_valid;
      v_vec   = ev_new_vec;
    end else begin
      v_valid = ta_valid;
      v_vec   = ta_vec;
    end
  end

  sf_bus_ctrl #(.TAG_W(TAG_W), .NC(NUM_CACHES)) u_bus (
    .cur_valid  (v_valid),
    .cur_tag    (ta_tag),
    .cur_vec    (v_vec),
    .bus_tag    (b_tag),
    .bus_op     (op),
    .bus_src    (bus_src),
    .hit        (bc_hit),
    .mask       (bc_mask),
    .upd_vec    (bc_upd_vec),
    .victim     (bc_victim),
    .victim_vec (bc_victim_vec)
  );

  // output stage: next-state and register processes
  logic                  sv_d, sh_d, bv_d;
  logic [NUM_CACHES-1:0] sm_d, bm_d;
  logic [ADDR_W-1:0]     ba_d;
  logic                  out_en;

  always_comb begin
    out_en = bus_valid || snoop_valid || binv_valid;
    sv_d   = bus_valid;
    sh_d   = bus_valid && bc_hit;
    sm_d   = bus_valid ? bc_mask : '0;
    bv_d   = bus_valid && bc_victim;
    ba_d   = {ta_tag, b_idx};
    bm_d   = bus_valid ? bc_victim_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoop_valid <= 1'b0;
      snoop_hit   <= 1'b0;
      snoop_mask  <= '0;
      binv_valid  <= 1'b0;
      binv_addr   <= '0;
      binv_mask   <= '0;
    end else if (out_en) begin
      snoop_valid <= sv_d;
      snoop_hit   <= sh_d;
      snoop_mask  <= sm_d;
      binv_valid  <= bv_d;
      binv_addr   <= ba_d;
      binv_mask   <= bm_d;
    end
  end
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int NUM_CACHES = 4,
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 8,
  localparam int SRC_W     = $clog2(NUM_CACHES),
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [SRC_W-1:0]      bus_src,
  input logic                  snoop_valid,
  input logic                  snoop_hit,
  input logic [NUM_CACHES-1:0] snoop_mask,
  input logic                  binv_valid,
  input logic [ADDR_W-1:0]     binv_addr,
  input logic [NUM_CACHES-1:0] binv_mask
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!snoop_valid && !binv_valid)); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> snoop_valid); // R2

  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && !snoop_hit) |-> (snoop_mask == '0)); // R2

  AST_REQ_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> !snoop_mask[$past(bus_src)]); // R5

  AST_BINV_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> (snoop_valid && !snoop_hit && binv_mask != '0)); // R7

  AST_BINV_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid ##1 binv_valid) |->
      (binv_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0]) &&
       binv_addr != $past(bus_addr))); // R7
endmodule

bind snoop_filter sf_checker #(
  .NUM_CACHES(NUM_CACHES), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
) u_sf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_addr    (bus_addr),
  .bus_src     (bus_src),
  .snoop_valid (snoop_valid),
  .snoop_hit   (snoop_hit),
  .snoop_mask  (snoop_mask),
  .binv_valid  (binv_valid),
  .binv_addr   (binv_addr),
  .binv_mask   (binv_mask)
);

// File: tb/tb_snoop_filter.sv
`timescale 1ns/1ps
module tb_snoop_filter;
  logic       clk;
  logic       rst_n;
  logic       bus_valid;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [1:0] bus_src;
  logic       evict_valid;
  logic [7:0] evict_addr;
  logic [1:0] evict_src;
  logic       snoop_valid, snoop_hit, binv_valid;
  logic [3:0] snoop_mask, binv_mask;
  logic [7:0] binv_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  snoop_filter #(.NUM_CACHES(4), .ENTRIES(16), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_src(bus_src),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_src(evict_src),
    .snoop_valid(snoop_valid), .snoop_hit(snoop_hit), .snoop_mask(snoop_mask),
    .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_mask(binv_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of traffic; outputs are read at the following falling edge
  task automatic cycle(input logic bv, input logic [7:0] ba, input logic bw, input logic [1:0] bs,
                       input logic ev, input logic [7:0] ea, input logic [1:0] es);
    @(negedge clk);
    bus_valid = bv; bus_addr = ba; bus_wr = bw; bus_src = bs;
    evict_valid = ev; evict_addr = ea; evict_src = es;
    @(negedge clk);
    bus_valid = 1'b0; evict_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s);
    cycle(1'b1, a, 1'b0, s, 1'b0, 8'h0, 2'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s);
    cycle(1'b1, a, 1'b1, s, 1'b0, 8'h0, 2'd0);
  endtask

  task automatic ev(input logic [7:0] a, input logic [1:0] s);
    cycle(1'b0, 8'h0, 1'b0, 2'd0, 1'b1, a, s);
  endtask

  task automatic t_reset();
    chk("R1 snoop_valid after reset", 32'(snoop_valid), 0);
    chk("R1 binv_valid after reset", 32'(binv_valid), 0);
  endtask

  task automatic t_read_sharing();
    rd(8'h13, 2'd0);
    chk("R2 miss hit", 32'(snoop_hit), 0);
    chk("R2 miss mask", 32'(snoop_mask), 0);
    chk("R2 miss valid", 32'(snoop_valid), 1);
    rd(8'h13, 2'd1);
    chk("R3 hit", 32'(snoop_hit), 1);
    chk("R3 mask c0", 32'(snoop_mask), 32'h1);
    rd(8'h13, 2'd2);
    chk("R3 mask c0c1", 32'(snoop_mask), 32'h3);
    rd(8'h13, 2'd1);
    chk("R5 requester excluded", 32'(snoop_mask), 32'h5);
    @(negedge clk);
    chk("R1 idle no result", 32'(snoop_valid), 0);
  endtask

  task automatic t_write();
    wr(8'h13, 2'd3);
    chk("R4 write mask", 32'(snoop_mask), 32'h7);
    rd(8'h13, 2'd0);
    chk("R4 writer only after write", 32'(snoop_mask), 32'h8);
  endtask

  task automatic t_evict();
    ev(8'h13, 2'd3);
    rd(8'h13, 2'd1);
    chk("R6 evicted bit cleared", 32'(snoop_mask), 32'h1);
    ev(8'h13, 2'd0);
    ev(8'h13, 2'd1);
    rd(8'h13, 2'd2);
    chk("R6 freed entry misses", 32'(snoop_hit), 0);
    chk("R6 freed entry no binv", 32'(binv_valid), 0);
  endtask

  task automatic t_conflict();
    rd(8'h23, 2'd1);
    chk("R7 binv valid", 32'(binv_valid), 1);
    chk("R10 binv addr", 32'(binv_addr), 32'h13);
    chk("R7 binv mask", 32'(binv_mask), 32'h4);
    chk("R7 conflict mask", 32'(snoop_mask), 0);
    rd(8'h13, 2'd0);
    chk("R7 binv addr back", 32'(binv_addr), 32'h23);
    chk("R7 binv mask back", 32'(binv_mask), 32'h2);
  endtask

  task automatic t_evict_miss();
    ev(8'h23, 2'd0);
    rd(8'h13, 2'd1);
    chk("R9 ignored eviction", 32'(snoop_mask), 32'h1);
    chk("R9 entry kept", 32'(snoop_hit), 1);
  endtask

  task automatic t_same_cycle();
    // vector is {0,1}; cache0 evicts while cache2 reads
    cycle(1'b1, 8'h13, 1'b0, 2'd2, 1'b1, 8'h13, 2'd0);
    chk("R8 evict before bus mask", 32'(snoop_mask), 32'h2);
    ev(8'h13, 2'd2);
    // only cache1 left; it evicts while a conflicting block arrives
    cycle(1'b1, 8'h33, 1'b0, 2'd3, 1'b1, 8'h13, 2'd1);
    chk("R8 freed no binv", 32'(binv_valid), 0);
    chk("R8 freed miss", 32'(snoop_hit), 0);
    rd(8'h33, 2'd0);
    chk("R8 new block tracked", 32'(snoop_mask), 32'h8);
  endtask

  task automatic t_write_miss();
    wr(8'h45, 2'd2);
    chk("R2 write miss mask", 32'(snoop_mask), 0);
    rd(8'h45, 2'd0);
    chk("R4 write miss alloc", 32'(snoop_mask), 32'h4);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_src = '0;
    evict_valid = 1'b0; evict_addr = '0; evict_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_sharing();
    t_write();
    t_evict();
    t_conflict();
    t_evict_miss();
    t_same_cycle();
    t_write_miss();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule